// File: doc/BRIEF.md
# Inverted Page Table Translator

This block turns a (process identifier, virtual page number) pair into a physical frame number. The table behind it has one slot per physical frame, not one slot per virtual page. Each slot records which process owns the frame and which of that process's virtual pages is loaded there, plus a valid bit. A translation compares the requested pair against every slot at once. The position of the matching slot is the frame number.

A lookup is presented on the request port for one cycle. One clock later the block returns a registered result: a hit flag with the frame number and the physical address, or a fault flag when no valid slot holds the pair. The physical address is the frame number placed above the page offset, which passes through unchanged.

A separate install port writes a pair, with its valid bit, into the slot chosen by a frame index. The same port can overwrite a mapping or clear it. Choosing a victim, accelerating the search with hashing, and servicing faults belong to the surrounding system.

Top module: `ipt_lookup`

## Requirements
- R1: After reset every slot is invalid, so any lookup faults, and res_valid, res_hit and res_fault are low until a lookup is made.
- R2: A lookup presented with lk_valid high returns res_valid high on the next clock edge, with res_hit high and res_frame equal to the index of the slot holding the requested pair.
- R3: A slot matches only when it is valid and both its process identifier and its virtual page equal the request. The same page under a different process identifier does not match.
- R4: When no valid slot matches, the result has res_fault high, res_hit low and res_frame equal to 0.
- R5: When several valid slots hold the requested pair, the slot with the lowest index gives the frame number.
- R6: res_paddr equals {res_frame, offset}, where offset is the lk_offset of the same lookup and fills the low OFF_W bits.
- R7: An install on one clock edge is seen by a lookup presented in the following cycle. A lookup presented in the same cycle as an install sees the table as it was before that install.
- R8: An install with inst_valid low clears the slot at inst_frame, so that slot no longer matches any pair.
- R9: An install replaces the whole slot: after it, the pair previously held at that frame no longer resolves to that frame.
- R10: res_hit and res_fault are never high together. Both are low in any cycle that follows a cycle without a lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lk_valid | input | 1 | A lookup request is present this cycle |
| lk_pid | input | PID_W | Process identifier of the request |
| lk_vpn | input | VPN_W | Virtual page number of the request |
| lk_offset | input | OFF_W | Page offset, passed through to the address |
| inst_en | input | 1 | Write one slot this cycle |
| inst_frame | input | FRAME_W | Index of the slot to write |
| inst_valid | input | 1 | Valid bit to store; low clears the slot |
| inst_pid | input | PID_W | Process identifier to store |
| inst_vpn | input | VPN_W | Virtual page number to store |
| res_valid | output | 1 | A lookup result is present |
| res_hit | output | 1 | The lookup found a matching slot |
| res_fault | output | 1 | The lookup found no matching slot |
| res_frame | output | FRAME_W | Frame number of the hit, 0 on a fault |
| res_paddr | output | FRAME_W+OFF_W | Physical address {frame, offset} |

## Verification
The case that is hardest to reach from the ports is the same pair held in more than one valid slot, because normal use never installs a page twice. Random stimulus draws process identifiers and page numbers from a very small range, so duplicates come up often. Directed steps also install one pair at a high index and then a low index, then clear the low one to show that the high slot takes over. A lookup issued in the same cycle as an install that creates its match is also driven on purpose, to check the ordering between the two ports.

// File: rtl/ipt_pkg.sv
// ipt_pkg: types and helpers shared by the inverted page table modules.
// Assumes nothing about the parameters beyond a frame count of at least one.
package ipt_pkg;

    // Outcome of the most recent lookup cycle, held in the result register.
    typedef enum logic [1:0] {
        LK_NONE  = 2'b00,
        LK_HIT   = 2'b01,
        LK_FAULT = 2'b10
    } lk_outcome_e;

    // Width of an index into n slots; never less than one bit.
    function automatic int unsigned idx_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/ipt_entry_store.sv
// ipt_entry_store: the slot array, one slot per physical frame.
// Each slot holds a valid bit, a process identifier and a virtual page.
// A write replaces the whole slot chosen by wr_frame on the clock edge.
// An index at or beyond FRAMES selects no slot, so such a write is dropped.
// Assumes synchronous active-low reset; reset clears every valid bit.
module ipt_entry_store #(
    parameter int unsigned FRAMES  = 16,
    parameter int unsigned PID_W   = 8,
    parameter int unsigned VPN_W   = 20,
    parameter int unsigned FRAME_W = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [FRAME_W-1:0]            wr_frame,
    input  logic                          wr_valid,
    input  logic [PID_W-1:0]              wr_pid,
    input  logic [VPN_W-1:0]              wr_vpn,
    output logic [FRAMES-1:0]             ent_valid,
    output logic [FRAMES-1:0][PID_W-1:0]  ent_pid,
    output logic [FRAMES-1:0][VPN_W-1:0]  ent_vpn
);

    logic [FRAMES-1:0] slot_sel;

    for (genvar gi = 0; gi < FRAMES; gi++) begin : g_slot
        // Decode whether this slot is the write target this cycle.
        always_comb begin
            slot_sel[gi] = wr_en && (wr_frame == FRAME_W'(gi));
        end

        // Hold the slot contents; reset invalidates, a selected write replaces.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_valid[gi] <= 1'b0;
                ent_pid[gi]   <= '0;
                ent_vpn[gi]   <= '0;
            end else if (slot_sel[gi]) begin
                ent_valid[gi] <= wr_valid;
                ent_pid[gi]   <= wr_pid;
                ent_vpn[gi]   <= wr_vpn;
            end
        end

        // R7
        install_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && (wr_frame == FRAME_W'(gi)))
            |=> (ent_valid[gi] == $past(wr_valid)) &&
                (ent_pid[gi] == $past(wr_pid)) &&
                (ent_vpn[gi] == $past(wr_vpn)));

        // R8
        clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !wr_valid && (wr_frame == FRAME_W'(gi)))
            |=> !ent_valid[gi]);

        // R9
        untouched_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && (wr_frame == FRAME_W'(gi)))
            |=> $stable(ent_valid[gi]) && $stable(ent_pid[gi]) && $stable(ent_vpn[gi]));
    end

endmodule

// File: rtl/ipt_match_array.sv
// ipt_match_array: compares the request pair against every slot in parallel.
// A slot raises its match bit only when it is valid and both fields agree.
// Purely combinational; assumes the slot outputs come straight from registers.
module ipt_match_array #(
    parameter int unsigned FRAMES = 16,
    parameter int unsigned PID_W  = 8,
    parameter int unsigned VPN_W  = 20
) (
    input  logic [FRAMES-1:0]             ent_valid,
    input  logic [FRAMES-1:0][PID_W-1:0]  ent_pid,
    input  logic [FRAMES-1:0][VPN_W-1:0]  ent_vpn,
    input  logic [PID_W-1:0]              key_pid,
    input  logic [VPN_W-1:0]              key_vpn,
    output logic [FRAMES-1:0]             match
);

    logic [FRAMES-1:0] pid_eq;
    logic [FRAMES-1:0] vpn_eq;

    for (genvar gi = 0; gi < FRAMES; gi++) begin : g_cmp
        // Compare the two tag fields of one slot and qualify by its valid bit.
        always_comb begin
            pid_eq[gi] = (ent_pid[gi] == key_pid);
            vpn_eq[gi] = (ent_vpn[gi] == key_vpn);
            match[gi]  = ent_valid[gi] && pid_eq[gi] && vpn_eq[gi];
        end
    end

endmodule

// File: rtl/ipt_low_first.sv
// ipt_low_first: priority encoder that picks the lowest set request bit.
// idx is 0 when no bit is set; any tells the caller whether idx is meaningful.
// Purely combinational; assumes N fits in W index bits.
module ipt_low_first #(
    parameter int unsigned N = 16,
    parameter int unsigned W = 4
) (
    input  logic [N-1:0] req,
    output logic         any,
    output logic [W-1:0] idx
);

    // Scan from the top down so the lowest set bit is the last one written.
    always_comb begin
        idx = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (req[k]) begin
                idx = W'(k);
            end
        end
    end

    // Flag whether any request bit is set.
    always_comb begin
        any = |req;
    end

endmodule

// File: rtl/ipt_lookup.sv
// ipt_lookup: inverted page table translator, top level.
// A request pair is matched against all slots; the lowest matching slot index
// becomes the frame number, registered one cycle after the request.
// A lookup sees the slot contents before any install on the same edge.
// Assumes synchronous active-low reset and FRAMES of at least one.
module ipt_lookup
    import ipt_pkg::*;
#(
    parameter int unsigned FRAMES  = 16,
    parameter int unsigned PID_W   = 8,
    parameter int unsigned VPN_W   = 20,
    parameter int unsigned OFF_W   = 12,
    localparam int unsigned FRAME_W = idx_width(FRAMES),
    localparam int unsigned PA_W    = FRAME_W + OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lk_valid,
    input  logic [PID_W-1:0]   lk_pid,
    input  logic [VPN_W-1:0]   lk_vpn,
    input  logic [OFF_W-1:0]   lk_offset,
    input  logic               inst_en,
    input  logic [FRAME_W-1:0] inst_frame,
    input  logic               inst_valid,
    input  logic [PID_W-1:0]   inst_pid,
    input  logic [VPN_W-1:0]   inst_vpn,
    output logic               res_valid,
    output logic               res_hit,
    output logic               res_fault,
    output logic [FRAME_W-1:0] res_frame,
    output logic [PA_W-1:0]    res_paddr
);

    logic [FRAMES-1:0]            slot_valid;
    logic [FRAMES-1:0][PID_W-1:0] slot_pid;
    logic [FRAMES-1:0][VPN_W-1:0] slot_vpn;
    logic [FRAMES-1:0]            match_vec;
    logic                         enc_any;
    logic [FRAME_W-1:0]           enc_idx;
    logic [FRAMES-1:0]            below_mask;

    lk_outcome_e                  outcome_q;
    logic                         valid_q;
    logic [FRAME_W-1:0]           frame_q;
    logic [OFF_W-1:0]             offset_q;

    ipt_entry_store #(
        .FRAMES (FRAMES),
        .PID_W  (PID_W),
        .VPN_W  (VPN_W),
        .FRAME_W(FRAME_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (inst_en),
        .wr_frame (inst_frame),
        .wr_valid (inst_valid),
        .wr_pid   (inst_pid),
        .wr_vpn   (inst_vpn),
        .ent_valid(slot_valid),
        .ent_pid  (slot_pid),
        .ent_vpn  (slot_vpn)
    );

    ipt_match_array #(
        .FRAMES(FRAMES),
        .PID_W (PID_W),
        .VPN_W (VPN_W)
    ) u_match (
        .ent_valid(slot_valid),
        .ent_pid  (slot_pid),
        .ent_vpn  (slot_vpn),
        .key_pid  (lk_pid),
        .key_vpn  (lk_vpn),
        .match    (match_vec)
    );

    ipt_low_first #(
        .N(FRAMES),
        .W(FRAME_W)
    ) u_pick (
        .req(match_vec),
        .any(enc_any),
        .idx(enc_idx)
    );

    // Capture the outcome of this cycle's lookup, or clear it when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q   <= 1'b0;
            outcome_q <= LK_NONE;
            frame_q   <= '0;
            offset_q  <= '0;
        end else begin
            valid_q <= lk_valid;
            if (lk_valid) begin
                outcome_q <= enc_any ? LK_HIT : LK_FAULT;
                frame_q   <= enc_any ? enc_idx : '0;
                offset_q  <= lk_offset;
            end else begin
                outcome_q <= LK_NONE;
                frame_q   <= '0;
                offset_q  <= '0;
            end
        end
    end

    // Drive the result ports from the registered outcome.
    always_comb begin
        res_valid = valid_q;
        res_hit   = (outcome_q == LK_HIT);
        res_fault = (outcome_q == LK_FAULT);
        res_frame = frame_q;
        res_paddr = {frame_q, offset_q};
    end

    // Mask of slots below the encoder's choice, used only by the check below.
    always_comb begin
        below_mask = (FRAMES'(1) << enc_idx) - FRAMES'(1);
    end

    // R5
    lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && enc_any)
        |-> match_vec[enc_idx] && ((match_vec & below_mask) == '0));

    // R2
    result_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_valid && (res_hit == $past(enc_any)));

    // R10
    hit_fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({res_hit, res_fault}) && ((res_hit || res_fault) == res_valid));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !res_hit && !res_fault);

    // R4
    fault_zero_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_fault |-> (res_frame == '0));

    // R6
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (res_paddr[OFF_W-1:0] == $past(lk_offset)));

endmodule

// File: tb/ipt_lookup_tb.sv
`timescale 1ns/1ps
module ipt_lookup_tb;

    localparam int FR  = 16;
    localparam int PW  = 8;
    localparam int VW  = 20;
    localparam int OW  = 12;
    localparam int FW  = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lk_valid = 1'b0;
    logic [PW-1:0] lk_pid = '0;
    logic [VW-1:0] lk_vpn = '0;
    logic [OW-1:0] lk_offset = '0;
    logic          inst_en = 1'b0;
    logic [FW-1:0] inst_frame = '0;
    logic          inst_valid = 1'b0;
    logic [PW-1:0] inst_pid = '0;
    logic [VW-1:0] inst_vpn = '0;
    logic          res_valid, res_hit, res_fault;
    logic [FW-1:0] res_frame;
    logic [FW+OW-1:0] res_paddr;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic          m_vld [FR];
    logic [PW-1:0] m_pid [FR];
    logic [VW-1:0] m_vpn [FR];

    always #2 clk = ~clk;

    ipt_lookup u_dut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_pid(lk_pid), .lk_vpn(lk_vpn), .lk_offset(lk_offset),
        .inst_en(inst_en), .inst_frame(inst_frame), .inst_valid(inst_valid),
        .inst_pid(inst_pid), .inst_vpn(inst_vpn),
        .res_valid(res_valid), .res_hit(res_hit), .res_fault(res_fault),
        .res_frame(res_frame), .res_paddr(res_paddr)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reference search: lowest valid slot holding the pair.
    function automatic int ref_find(input logic [PW-1:0] p, input logic [VW-1:0] v);
        for (int k = 0; k < FR; k++) begin
            if (m_vld[k] && m_pid[k] == p && m_vpn[k] == v) return k;
        end
        return -1;
    endfunction

    task automatic model_write(input int f, input logic vl, input logic [PW-1:0] p, input logic [VW-1:0] v);
        m_vld[f] = vl; m_pid[f] = p; m_vpn[f] = v;
    endtask

    task automatic check_result(input string req, input int ef, input logic [OW-1:0] off);
        logic [FW-1:0] fr;
        fr = (ef >= 0) ? FW'(ef) : '0;
        chk({req, " res_valid"}, 64'(res_valid), 64'd1);
        chk({req, " res_hit"},   64'(res_hit),   64'(ef >= 0));
        chk({req, " res_fault"}, 64'(res_fault), 64'(ef < 0));
        chk({req, " res_frame"}, 64'(res_frame), 64'(fr));
        chk({req, " res_paddr"}, 64'(res_paddr), 64'({fr, off}));
    endtask

    task automatic install(input int f, input logic vl, input logic [PW-1:0] p, input logic [VW-1:0] v);
        @(negedge clk);
        inst_en = 1'b1; inst_frame = FW'(f); inst_valid = vl; inst_pid = p; inst_vpn = v;
        @(negedge clk);
        inst_en = 1'b0;
        model_write(f, vl, p, v);
    endtask

    task automatic lookup(input string req, input logic [PW-1:0] p, input logic [VW-1:0] v, input logic [OW-1:0] off);
        int ef;
        @(negedge clk);
        lk_valid = 1'b1; lk_pid = p; lk_vpn = v; lk_offset = off;
        ef = ref_find(p, v);
        @(negedge clk);
        lk_valid = 1'b0;
        check_result(req, ef, off);
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int ef;
        void'($urandom(32'd4242));
        for (int k = 0; k < FR; k++) model_write(k, 1'b0, '0, '0);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 res_valid at reset", 64'(res_valid), 64'd0);
        chk("R1 res_hit at reset",   64'(res_hit),   64'd0);
        chk("R1 res_fault at reset", 64'(res_fault), 64'd0);
        rst_n = 1'b1;
        // R1 empty table faults; R4 frame zero
        lookup("R1 R4 empty table", 8'h00, 20'h00000, 12'hABC);
        // R2 R6 simple hit
        install(5, 1'b1, 8'h03, 20'h01234);
        lookup("R2 R6 hit frame 5", 8'h03, 20'h01234, 12'h5A5);
        // R3 same page, other process
        lookup("R3 pid mismatch", 8'h04, 20'h01234, 12'h001);
        lookup("R3 vpn mismatch", 8'h03, 20'h01235, 12'h002);
        // R5 duplicates: lowest index wins
        install(9, 1'b1, 8'h07, 20'hBEEF0);
        install(2, 1'b1, 8'h07, 20'hBEEF0);
        lookup("R5 lowest of two", 8'h07, 20'hBEEF0, 12'hFFF);
        // R8 clearing the low slot hands over to the high one
        install(2, 1'b0, 8'h07, 20'hBEEF0);
        lookup("R8 cleared slot", 8'h07, 20'hBEEF0, 12'h123);
        // R9 overwrite frame 9 with another pair
        install(9, 1'b1, 8'h01, 20'h00009);
        lookup("R9 old pair gone", 8'h07, 20'hBEEF0, 12'h321);
        lookup("R9 new pair", 8'h01, 20'h00009, 12'h777);
        // R7 same-cycle install and lookup sees old table, next cycle sees new
        @(negedge clk);
        inst_en = 1'b1; inst_frame = 4'd12; inst_valid = 1'b1; inst_pid = 8'h22; inst_vpn = 20'h0C0DE;
        lk_valid = 1'b1; lk_pid = 8'h22; lk_vpn = 20'h0C0DE; lk_offset = 12'h0AA;
        ef = ref_find(8'h22, 20'h0C0DE);
        @(negedge clk);
        inst_en = 1'b0; lk_valid = 1'b0;
        model_write(12, 1'b1, 8'h22, 20'h0C0DE);
        check_result("R7 same cycle", ef, 12'h0AA);
        // R10 idle cycle after a lookup: both flags low
        @(negedge clk);
        chk("R10 idle hit",   64'(res_hit),   64'd0);
        chk("R10 idle fault", 64'(res_fault), 64'd0);
        chk("R10 idle valid", 64'(res_valid), 64'd0);
        lookup("R7 next cycle", 8'h22, 20'h0C0DE, 12'h0BB);
        // Random mix with a narrow key range to force duplicates (R2 R3 R5 R8 R9)
        for (int it = 0; it < 600; it++) begin
            logic [PW-1:0] p;
            logic [VW-1:0] v;
            p = PW'($urandom % 3);
            v = VW'($urandom % 4);
            if ($urandom % 2 == 0)
                install(int'($urandom % FR), ($urandom % 4) != 0, p, v);
            else
                lookup("R2 R5 random", p, v, OW'($urandom));
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule